// File: doc/BRIEF.md
# Nested Priority-Level Interrupt Controller

This block chooses one interrupt request at a time from a set of peripheral request lines and hands it, with its vector address, to a small CPU model. Software gives each source a 3-bit priority level. A source is only taken when its level is strictly above the level the CPU is currently working at. Level 0 therefore switches a source off completely.

When the CPU takes an interrupt, the block saves the working level on an internal level stack. It then raises the working level to that of the taken source and sets the global mask bit. On a return from interrupt, the saved level comes back and the mask bit clears. Lower-level requests that arrive during a higher-level routine wait. They are served in falling level order as the working level drops.

The vector address is a programmable base byte joined to a per-source offset byte. If a request goes away between being signalled and the CPU's acknowledge, a fixed spurious offset is supplied instead.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset:
  - every source level is 1 and the vector base is 0xFF;
  - the working level is 0 and the global mask bit is set;
  - the level stack is empty, the error flag is low and `irq_out` is low.
- R2: A source is eligible only when all of these hold in a cycle: its request is high, its enable is high, the mask bit is clear, and its level is strictly greater than the working level. `irq_out` is a register that shows whether any source was eligible at the previous clock edge.
- R3: A source set to level 0 is never eligible, whatever its request and enable inputs.
- R4: An acknowledge while a source is eligible and the stack is not full does three things at the next edge:
  - pushes the working level onto the stack;
  - makes the winner's level the working level;
  - sets the mask bit.
- R5: The winner is the eligible source with the highest level. On equal levels, the lower source index wins, since its vector sits nearer the top of memory.
- R6: `irq_vec` is combinational. It is {base, 0xFE - 2*index} of the current winner, so source 0 has the highest offset.
- R7: A configuration write takes effect at the next edge:
  - address k < NUM_SRC writes wdata[2:0] as the level of source k;
  - address NUM_SRC writes the 8-bit vector base;
  - any other address changes nothing.
- R8: When no source is eligible, `irq_vec` is {base, 0x10}, the spurious vector. An acknowledge in that state pushes the working level, leaves the working level unchanged and sets the mask bit.
- R9: A return from interrupt with a non-empty stack pops the saved level into the working level and clears the mask bit.
- R10: A request below or equal to the working level stays pending and is taken after returns lower the working level beneath it.
- R11: Stack errors:
  - an acknowledge with the stack full (STK_DEPTH entries) is ignored and sets the error flag;
  - a return with the stack empty is ignored and sets the error flag;
  - the error flag stays set until reset.
- R12: Only one CPU command acts in a cycle, chosen in this order: acknowledge, then return, then mask clear (`cpu_cli`), then mask set (`cpu_sei`). While the mask bit is set, no source is eligible.
- R13: The status word places the working level in bits [10:8] and the mask bit in bit 4. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_SRC | Level-held request per source |
| irq_en | input | NUM_SRC | Local enable per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(NUM_SRC+1) | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| cpu_ack | input | 1 | CPU takes the interrupt and fetches the vector this cycle |
| cpu_rti | input | 1 | CPU return from interrupt |
| cpu_cli | input | 1 | Clear global mask bit |
| cpu_sei | input | 1 | Set global mask bit |
| irq_out | output | 1 | Registered interrupt request to CPU |
| irq_vec | output | 16 | Vector address for the current winner or spurious vector |
| cur_lvl | output | 3 | Current working level |
| gmask | output | 1 | Global mask bit |
| stat_word | output | 16 | Status word with level and mask bit |
| stk_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
`irq_vec` follows the inputs and the present state in the same cycle. `irq_out` trails eligibility by exactly one edge. Working level, mask bit, stack error and configuration changes show one edge after the command or write that causes them.

The bench drives inputs 6 ns after a falling edge. It compares every output with its behavioural model 4 ns after the following falling edge, so each result is sampled in the first cycle it is due. Directed checks on nesting order, ties, spurious fetch and stack limits are placed at those same points.

// File: rtl/prio_irq_pkg.sv
// Package: shared level type and vector offset arithmetic for the
// priority-level interrupt controller. Assumes 8-bit vector offsets.
package prio_irq_pkg;
    localparam int LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;

    // Offset byte used when the acknowledged request has vanished
    localparam logic [7:0] SPUR_OFS = 8'h10;

    // Source 0 sits at the top offset, each next source two bytes lower
    function automatic logic [7:0] vec_ofs(input int idx);
        return 8'(8'hFE - 2 * idx);
    endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
// Configuration registers: one priority level per source plus the vector
// base byte. Write-only, one write per cycle, synchronous active-low reset.
// Assumes NUM_SRC fits in AW bits with one spare code for the base.
module irq_cfg_regs
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int AW      = $clog2(NUM_SRC + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [AW-1:0]                 addr,
    input  logic [7:0]                    wdata,
    output logic [NUM_SRC-1:0][LVL_W-1:0] lvls,
    output logic [7:0]                    vbase
);
    logic [LVL_W-1:0] lvl_q [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
        // Holds the level of source g; a write to address g replaces it
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_q[g] <= LVL_W'(1);
            else if (we && addr == AW'(g))
                lvl_q[g] <= wdata[LVL_W-1:0];
        end
        assign lvls[g] = lvl_q[g];
    end

    // Holds the vector base byte; written at the address after the last source
    always_ff @(posedge clk) begin
        if (!rst_n)
            vbase <= 8'hFF;
        else if (we && addr == AW'(NUM_SRC))
            vbase <= wdata;
    end
endmodule

// File: rtl/irq_arbiter.sv
// Arbiter: marks eligible sources and picks the one with the highest level,
// lowest index on ties. Purely combinational. Assumes NUM_SRC >= 2.
module irq_arbiter
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IW      = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]            req,
    input  logic [NUM_SRC-1:0]            en,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvls,
    input  lvl_t                          cur,
    input  logic                          mask,
    output logic                          any,
    output logic [IW-1:0]                 win_idx,
    output lvl_t                          win_lvl
);
    // Scans from the highest index down so an equal level at a lower index replaces the pick
    always_comb begin
        any     = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i] && en[i] && !mask && lvls[i] > cur &&
                (!any || lvls[i] >= win_lvl)) begin
                any     = 1'b1;
                win_idx = IW'(i);
                win_lvl = lvls[i];
            end
        end
    end
endmodule

// File: rtl/irq_ctx.sv
// Context keeper: working level, global mask bit, saved-level stack and the
// sticky stack error. Commands are prioritised ack > rti > cli > sei.
// Assumes the caller reports whether an acknowledge found a real winner.
module irq_ctx
    import prio_irq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PW    = $clog2(DEPTH + 1),
    parameter int SW    = $clog2(DEPTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    input  logic ack_hit,
    input  lvl_t ack_lvl,
    input  logic rti,
    input  logic cli,
    input  logic sei,
    output lvl_t wlvl,
    output logic mask,
    output logic err
);
    lvl_t          stk [DEPTH];
    logic [PW-1:0] sp;
    logic          full, empty;
    logic [SW-1:0] top_idx;

    assign full    = (sp == PW'(DEPTH));
    assign empty   = (sp == '0);
    assign top_idx = SW'(sp - 1'b1);

    // Stores the working level into the next free slot on an accepted ack
    always_ff @(posedge clk) begin
        if (ack && !full)
            stk[sp[SW-1:0]] <= wlvl;
    end

    // Updates pointer, level, mask and error for the single winning command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp   <= '0;
            wlvl <= '0;
            mask <= 1'b1;
            err  <= 1'b0;
        end else if (ack) begin
            if (full) begin
                err <= 1'b1;
            end else begin
                sp   <= sp + 1'b1;
                mask <= 1'b1;
                if (ack_hit)
                    wlvl <= ack_lvl;
            end
        end else if (rti) begin
            if (empty) begin
                err <= 1'b1;
            end else begin
                sp   <= sp - 1'b1;
                wlvl <= stk[top_idx];
                mask <= 1'b0;
            end
        end else if (cli) begin
            mask <= 1'b0;
        end else if (sei) begin
            mask <= 1'b1;
        end
    end

    AST_PUSH_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && sp != PW'(DEPTH)) |=> mask); // R4
    AST_POP_UNMASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && rti && sp != '0) |=> !mask); // R9
    AST_SPUR_KEEPS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !ack_hit && sp != PW'(DEPTH)) |=> (wlvl == $past(wlvl))); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R11
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && sp == PW'(DEPTH)) |=> ($stable(sp) && err)); // R11
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top: nested priority-level interrupt controller. Combines configuration
// registers, arbiter and context keeper; registers the request to the CPU
// and forms the vector address. Assumes requests are level-held by sources.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC   = 8,
    parameter int STK_DEPTH = 8,
    parameter int AW        = $clog2(NUM_SRC + 1),
    parameter int IW        = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic               cfg_we,
    input  logic [AW-1:0]      cfg_addr,
    input  logic [7:0]         cfg_wdata,
    input  logic               cpu_ack,
    input  logic               cpu_rti,
    input  logic               cpu_cli,
    input  logic               cpu_sei,
    output logic               irq_out,
    output logic [15:0]        irq_vec,
    output logic [2:0]         cur_lvl,
    output logic               gmask,
    output logic [15:0]        stat_word,
    output logic               stk_err
);
    logic [NUM_SRC-1:0][LVL_W-1:0] lvls;
    logic [7:0]                    vbase;
    logic                          irq_any;
    logic [IW-1:0]                 win_idx;
    lvl_t                          win_lvl;
    lvl_t                          wlvl;

    irq_cfg_regs #(.NUM_SRC(NUM_SRC), .AW(AW)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .lvls  (lvls),
        .vbase (vbase)
    );

    irq_arbiter #(.NUM_SRC(NUM_SRC), .IW(IW)) u_arb (
        .req     (irq_req),
        .en      (irq_en),
        .lvls    (lvls),
        .cur     (wlvl),
        .mask    (gmask),
        .any     (irq_any),
        .win_idx (win_idx),
        .win_lvl (win_lvl)
    );

    irq_ctx #(.DEPTH(STK_DEPTH)) u_ctx (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (cpu_ack),
        .ack_hit (irq_any),
        .ack_lvl (win_lvl),
        .rti     (cpu_rti),
        .cli     (cpu_cli),
        .sei     (cpu_sei),
        .wlvl    (wlvl),
        .mask    (gmask),
        .err     (stk_err)
    );

    // Registers the any-eligible indication toward the CPU
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_out <= 1'b0;
        else
            irq_out <= irq_any;
    end

    // Forms the vector from the base byte and the winner or spurious offset
    always_comb begin
        irq_vec = {vbase, irq_any ? vec_ofs(int'(win_idx)) : SPUR_OFS};
    end

    assign cur_lvl   = wlvl;
    assign stat_word = {5'b0, wlvl, 3'b0, gmask, 4'b0};

    AST_WIN_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> (win_lvl > cur_lvl)); // R2
    AST_NO_ZERO_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> (win_lvl != '0)); // R3
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        gmask |-> !irq_any); // R12
    AST_ACK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && irq_any && !stk_err) |=> (stk_err || cur_lvl > $past(cur_lvl))); // R4
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    localparam int N  = 8;
    localparam int D  = 8;
    localparam int AW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic [N-1:0]  irq_en = '1;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic          cpu_ack = 1'b0, cpu_rti = 1'b0, cpu_cli = 1'b0, cpu_sei = 1'b0;
    logic          irq_out, gmask, stk_err;
    logic [15:0]   irq_vec, stat_word;
    logic [2:0]    cur_lvl;

    int n_chk = 0;
    int n_fail = 0;

    prio_irq_ctrl #(.NUM_SRC(N), .STK_DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cpu_ack(cpu_ack), .cpu_rti(cpu_rti), .cpu_cli(cpu_cli), .cpu_sei(cpu_sei),
        .irq_out(irq_out), .irq_vec(irq_vec), .cur_lvl(cur_lvl), .gmask(gmask),
        .stat_word(stat_word), .stk_err(stk_err)
    );

    always #10 clk = ~clk;

    // Behavioural reference model
    int m_lvl [N];
    int m_base, m_wl;
    bit m_mk, m_err, m_irq, m_started;
    int m_stk [$];

    function automatic int m_best();
        int b = -1;
        for (int i = 0; i < N; i++)
            if (irq_req[i] && irq_en[i] && !m_mk && m_lvl[i] > m_wl &&
                (b < 0 || m_lvl[i] > m_lvl[b]))
                b = i;
        return b;
    endfunction

    always @(posedge clk) begin
        int b;
        m_started = 1'b1;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_lvl[i] = 1;
            m_base = 255; m_wl = 0; m_mk = 1'b1; m_err = 1'b0; m_irq = 1'b0;
            m_stk.delete();
        end else begin
            b = m_best();
            m_irq = (b >= 0);
            if (cpu_ack) begin
                if (m_stk.size() == D) m_err = 1'b1;
                else begin
                    m_stk.push_back(m_wl);
                    if (b >= 0) m_wl = m_lvl[b];
                    m_mk = 1'b1;
                end
            end else if (cpu_rti) begin
                if (m_stk.size() == 0) m_err = 1'b1;
                else begin
                    m_wl = m_stk.pop_back();
                    m_mk = 1'b0;
                end
            end else if (cpu_cli) m_mk = 1'b0;
            else if (cpu_sei) m_mk = 1'b1;
            if (cfg_we) begin
                if (int'(cfg_addr) < N) m_lvl[cfg_addr] = int'(cfg_wdata[2:0]);
                else if (int'(cfg_addr) == N) m_base = int'(cfg_wdata);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        int b, ev;
        #4;
        if (m_started) begin
            b  = m_best();
            ev = m_base * 256 + ((b >= 0) ? (254 - 2 * b) : 16);
            chk("R2 irq_out", int'(irq_out), int'(m_irq));
            chk("R6/R8 irq_vec", int'(irq_vec), ev);
            chk("R4/R9 cur_lvl", int'(cur_lvl), m_wl);
            chk("R12 gmask", int'(gmask), int'(m_mk));
            chk("R13 stat_word", int'(stat_word), m_wl * 256 + (m_mk ? 16 : 0));
            chk("R11 stk_err", int'(stk_err), int'(m_err));
        end
    end

    task automatic step();
        @(negedge clk);
        #6;
    endtask

    task automatic cfg_wr(input int a, input int d);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = 8'(d);
        step();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_ack(); cpu_ack = 1'b1; step(); cpu_ack = 1'b0; endtask
    task automatic pulse_rti(); cpu_rti = 1'b1; step(); cpu_rti = 1'b0; endtask
    task automatic pulse_cli(); cpu_cli = 1'b1; step(); cpu_cli = 1'b0; endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(); step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 irq_out", int'(irq_out), 0);
        chk("R1 cur_lvl", int'(cur_lvl), 0);
        chk("R1 gmask", int'(gmask), 1);
        chk("R1 stat_word", int'(stat_word), 16'h0010);
        chk("R1 stk_err", int'(stk_err), 0);
        chk("R1 irq_vec", int'(irq_vec), 16'hFF10);

        // R12 mask blocks; R2 request appears one edge after eligibility
        irq_req[2] = 1'b1;
        step(); step();
        chk("R12 masked", int'(irq_out), 0);
        pulse_cli();
        chk("R2 latency", int'(irq_out), 0);
        step();
        chk("R2 irq_out", int'(irq_out), 1);
        chk("R6 vec src2", int'(irq_vec), 16'hFFFA);

        // R4 acceptance
        cpu_ack = 1'b1; #1;
        chk("R6 vec at ack", int'(irq_vec), 16'hFFFA);
        step(); cpu_ack = 1'b0; irq_req[2] = 1'b0;
        chk("R4 cur_lvl", int'(cur_lvl), 1);
        chk("R4 gmask", int'(gmask), 1);
        chk("R13 stat", int'(stat_word), 16'h0110);

        // R10 / R5 nesting and pending order
        cfg_wr(5, 5); cfg_wr(6, 2); cfg_wr(1, 2);
        irq_req[5] = 1'b1; irq_req[6] = 1'b1; irq_req[1] = 1'b1;
        pulse_cli(); step();
        chk("R5 highest level", int'(irq_vec), 16'hFFF4);
        pulse_ack();
        chk("R4 nest lvl", int'(cur_lvl), 5);
        pulse_cli(); step(); step();
        chk("R10 pending held", int'(irq_out), 0);
        irq_req[5] = 1'b0;
        pulse_rti();
        chk("R9 restore", int'(cur_lvl), 1);
        chk("R9 unmask", int'(gmask), 0);
        step();
        chk("R10 resumes", int'(irq_out), 1);
        chk("R5 tie lower index", int'(irq_vec), 16'hFFFC);
        pulse_ack(); irq_req[1] = 1'b0;
        chk("R4 lvl2", int'(cur_lvl), 2);
        pulse_cli(); step(); step();
        chk("R10 equal level waits", int'(irq_out), 0);
        pulse_rti();
        chk("R9 back to 1", int'(cur_lvl), 1);
        step();
        chk("R10 src6 vec", int'(irq_vec), 16'hFFF2);
        pulse_ack(); irq_req[6] = 1'b0;
        chk("R4 src6 lvl", int'(cur_lvl), 2);
        pulse_rti(); pulse_rti();
        chk("R9 unwind", int'(cur_lvl), 0);

        // R3 level zero never taken
        cfg_wr(3, 0);
        irq_req[3] = 1'b1;
        step(); step();
        chk("R3 level0 irq_out", int'(irq_out), 0);
        chk("R3 level0 vec", int'(irq_vec), 16'hFF10);
        irq_req[3] = 1'b0;

        // R8 spurious vector
        irq_req[4] = 1'b1;
        step(); step();
        chk("R6 src4 vec", int'(irq_vec), 16'hFFF6);
        irq_req[4] = 1'b0; cpu_ack = 1'b1; #1;
        chk("R8 spurious vec", int'(irq_vec), 16'hFF10);
        step(); cpu_ack = 1'b0;
        chk("R8 level kept", int'(cur_lvl), 0);
        chk("R8 mask set", int'(gmask), 1);
        pulse_rti();

        // R7 configuration: base write, ignored address
        cfg_wr(8, 8'h40);
        cfg_wr(9, 7);
        chk("R7 base", int'(irq_vec), 16'h4010);
        irq_req[0] = 1'b1;
        step(); step();
        chk("R7 src0 level still 1", int'(irq_vec), 16'h40FE);
        irq_req[0] = 1'b0;

        // R11 underflow
        pulse_rti();
        chk("R11 underflow err", int'(stk_err), 1);
        chk("R11 underflow lvl", int'(cur_lvl), 0);
        step();

        // R12 ack beats rti; R11 overflow
        rst_n = 1'b0; step(); rst_n = 1'b1; step();
        cpu_ack = 1'b1; cpu_rti = 1'b1; step(); cpu_ack = 1'b0; cpu_rti = 1'b0;
        chk("R12 ack over rti err", int'(stk_err), 0);
        chk("R12 ack over rti mask", int'(gmask), 1);
        for (int k = 0; k < D - 1; k++) pulse_ack();
        chk("R11 full no err", int'(stk_err), 0);
        pulse_ack();
        chk("R11 overflow err", int'(stk_err), 1);
        chk("R11 overflow lvl", int'(cur_lvl), 0);
        step(); step();
        finish_run();
    end
endmodule